// File: doc/BRIEF.md
# One-Time-Programmable Trim Fuse Sequencer

This block stores a small trim code permanently in a row of one-time fuses. Software first writes a working code, which takes effect at once, and tunes the analog setting until it is right. It then issues a program command. The sequencer first blows a test fuse to prove that the programming setup works. It then blows the data fuses one per cycle, compares the sensed fuse row with the working code, and finally blows a lock fuse. A 2-bit status word reports the outcome, and a failed data compare can be retried with a new command.

The block talks to the fuse array through a single-cycle blow strobe with a fuse index, plus static sense lines for every fuse. Before the lock fuse is blown, the active code comes from the working register. After it is blown, the active code comes from the sensed data fuses, and this also holds after every later reset.

Top module: `otp_trim_ctrl`

## Requirements
- R1: On reset with the lock fuse unblown, the working code is preset to midscale (bit CODE_W-1 set, so 32 for 6 bits), `busy` is 0, `status` is 00 (ready), `fuse_blow` is 0, and `active_code` is 32.
- R2: When `busy` is low and the block is not locked, a `wr_en` pulse loads `wr_code` into the working register, and `active_code` shows the new value within two cycles.
- R3: A program run starts only on a `cmd_valid` cycle whose top `cmd_byte` bit is 1. The other bits of the byte are ignored, and a command with the top bit 0 causes no strobe and no `busy`.
- R4: The first step strobes fuse index CODE_W (6), which is the test fuse. The test sense is read one cycle after the strobe. If it reads 0, the run stops with `status` 01 after 2 busy cycles.
- R5: After a good test fuse, data fuse indices 0 to CODE_W-1 are visited in ascending order on consecutive cycles. `fuse_blow` is raised for index i only when bit i of the working code is 1.
- R6: One cycle after the last data step, the sensed data fuses are compared with the working code. A mismatch ends the run with `status` 10 (fatal) and no lock strobe.
- R7: On a match, index CODE_W+1 (7), the lock fuse, is strobed. If its sense reads 1 one cycle later, `status` becomes 11 (locked) and `active_code` shows the sensed data fuses. If it reads 0, `status` becomes 10.
- R8: After `status` 10, a new command with the same code is accepted. If the test fuse already senses blown, the test step is skipped and the run takes 9 busy cycles.
- R9: Once `status` is 11, program commands cause no strobe and no `busy`, and working-register writes do not change `active_code`.
- R10: A `wr_en` pulse while `busy` is high does not change the working register.
- R11: A reset with the lock fuse sensed blown gives `status` 11 and `active_code` equal to the sensed data fuses.
- R12: A full run takes 11 busy cycles, and `status` keeps its old value until the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| wr_en | input | 1 | Working-register write strobe |
| wr_code | input | CODE_W | Code to write into the working register |
| cmd_valid | input | 1 | Instruction byte valid |
| cmd_byte | input | CMD_W | Instruction byte; top bit requests programming |
| data_fuse_q | input | CODE_W | Sensed state of the data fuses |
| test_fuse_q | input | 1 | Sensed state of the test fuse |
| lock_fuse_q | input | 1 | Sensed state of the lock fuse |
| fuse_blow | output | 1 | Single-cycle fuse blow strobe |
| fuse_idx | output | IDX_W | Fuse addressed by the strobe (data 0..CODE_W-1, test CODE_W, lock CODE_W+1) |
| busy | output | 1 | Program sequence in progress |
| status | output | 2 | 00 ready, 01 test fuse fault, 10 fatal data fault, 11 locked |
| active_code | output | CODE_W | Code driving the trimmed circuit |

## Verification
The assertions check several rules on every cycle. Strobes occur only inside a busy window, and a locked status never leaves the locked state. The working code holds while busy, and the status is frozen until busy falls. A run starts only on a command with its top bit set, and the lock strobe appears only when the sensed fuses equal the working code. Other behaviour can only be shown by the bench's scenarios, which use a fuse model with injected faults. These cover the exact run lengths for each path and the test-fuse and lock-fuse failures. They also cover the retry path that skips the test step, writes ignored while busy, and the return of the fused code after a later reset.

// File: rtl/otp_trim_pkg.sv
package otp_trim_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TEST,
    SQ_TSENSE,
    SQ_DATA,
    SQ_VERIFY,
    SQ_LOCK,
    SQ_LSENSE
  } seq_state_t;

  localparam logic [1:0] ST_READY    = 2'b00;
  localparam logic [1:0] ST_SETUP    = 2'b01;
  localparam logic [1:0] ST_FATAL    = 2'b10;
  localparam logic [1:0] ST_LOCKED   = 2'b11;

endpackage

// File: rtl/otp_trim_workreg.sv
module otp_trim_workreg #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              busy,
  output logic [CODE_W-1:0] work_code
);
  localparam logic [CODE_W-1:0] PRESET = CODE_W'(1) << (CODE_W - 1);

  always_ff @(posedge clk) begin
    if (rst)
      work_code <= PRESET;
    else if (wr_en && !busy)
      work_code <= wr_code;
  end
endmodule

// File: rtl/otp_trim_seq.sv
module otp_trim_seq
  import otp_trim_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CMD_W  = 8,
  localparam int IDX_W = $clog2(CODE_W + 2),
  localparam int CNT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic [CODE_W-1:0] work_code,
  input  logic [CODE_W-1:0] data_fuse_q,
  input  logic              test_fuse_q,
  input  logic              lock_fuse_q,
  output logic              fuse_blow,
  output logic [IDX_W-1:0]  fuse_idx,
  output logic              busy,
  output logic [1:0]        status
);
  localparam logic [IDX_W-1:0] IDX_TEST = IDX_W'(CODE_W);
  localparam logic [IDX_W-1:0] IDX_LOCK = IDX_W'(CODE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CODE_W - 1);

  seq_state_t       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [1:0]       status_n;
  logic             start;

  assign start = cmd_valid && cmd_byte[CMD_W-1] && (status != ST_LOCKED);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    status_n = status;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        cnt_n   = '0;
        state_n = test_fuse_q ? SQ_DATA : SQ_TEST;
      end
      SQ_TEST:   state_n = SQ_TSENSE;
      SQ_TSENSE: if (test_fuse_q) begin
        state_n = SQ_DATA;
        cnt_n   = '0;
      end else begin
        state_n  = SQ_IDLE;
        status_n = ST_SETUP;
      end
      SQ_DATA: if (cnt_q == CNT_LAST) state_n = SQ_VERIFY;
               else cnt_n = cnt_q + 1'b1;
      SQ_VERIFY: if (data_fuse_q == work_code) state_n = SQ_LOCK;
                 else begin
                   state_n  = SQ_IDLE;
                   status_n = ST_FATAL;
                 end
      SQ_LOCK:   state_n = SQ_LSENSE;
      SQ_LSENSE: begin
        state_n  = SQ_IDLE;
        status_n = lock_fuse_q ? ST_LOCKED : ST_FATAL;
      end
      default:   state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      status    <= lock_fuse_q ? ST_LOCKED : ST_READY;
      busy      <= 1'b0;
      fuse_blow <= 1'b0;
      fuse_idx  <= '0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      status    <= status_n;
      busy      <= (state_n != SQ_IDLE);
      fuse_blow <= (state_n == SQ_TEST) || (state_n == SQ_LOCK) ||
                   ((state_n == SQ_DATA) && work_code[cnt_n]);
      unique case (state_n)
        SQ_TEST: fuse_idx <= IDX_TEST;
        SQ_LOCK: fuse_idx <= IDX_LOCK;
        SQ_DATA: fuse_idx <= IDX_W'(cnt_n);
        default: fuse_idx <= '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_trim_codesel.sv
module otp_trim_codesel
  import otp_trim_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        status,
  input  logic              lock_fuse_q,
  input  logic [CODE_W-1:0] work_code,
  input  logic [CODE_W-1:0] data_fuse_q,
  output logic [CODE_W-1:0] active_code
);
  localparam logic [CODE_W-1:0] PRESET = CODE_W'(1) << (CODE_W - 1);

  always_ff @(posedge clk) begin
    if (rst)
      active_code <= lock_fuse_q ? data_fuse_q : PRESET;
    else
      active_code <= (status == ST_LOCKED) ? data_fuse_q : work_code;
  end
endmodule

// File: rtl/otp_trim_ctrl.sv
module otp_trim_ctrl #(
  parameter int CODE_W = 6,
  parameter int CMD_W  = 8,
  localparam int IDX_W = $clog2(CODE_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic [CODE_W-1:0] data_fuse_q,
  input  logic              test_fuse_q,
  input  logic              lock_fuse_q,
  output logic              fuse_blow,
  output logic [IDX_W-1:0]  fuse_idx,
  output logic              busy,
  output logic [1:0]        status,
  output logic [CODE_W-1:0] active_code
);
  logic [CODE_W-1:0] work_code;

  otp_trim_workreg #(.CODE_W(CODE_W)) u_work (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .busy(busy), .work_code(work_code)
  );

  otp_trim_seq #(.CODE_W(CODE_W), .CMD_W(CMD_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .work_code(work_code), .data_fuse_q(data_fuse_q),
    .test_fuse_q(test_fuse_q), .lock_fuse_q(lock_fuse_q),
    .fuse_blow(fuse_blow), .fuse_idx(fuse_idx), .busy(busy), .status(status)
  );

  otp_trim_codesel #(.CODE_W(CODE_W)) u_sel (
    .clk(clk), .rst(rst), .status(status), .lock_fuse_q(lock_fuse_q),
    .work_code(work_code), .data_fuse_q(data_fuse_q),
    .active_code(active_code)
  );
endmodule

// File: rtl/otp_trim_chk.sv
module otp_trim_chk #(
  parameter int CODE_W = 6,
  parameter int CMD_W  = 8,
  localparam int IDX_W = $clog2(CODE_W + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_byte,
  input logic [CODE_W-1:0] data_fuse_q,
  input logic [CODE_W-1:0] work_code,
  input logic              fuse_blow,
  input logic [IDX_W-1:0]  fuse_idx,
  input logic              busy,
  input logic [1:0]        status
);
  localparam logic [IDX_W-1:0] IDX_LOCK = IDX_W'(CODE_W + 1);

  p_blow_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    fuse_blow |-> busy);

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11) |=> (status == 2'b11));

  p_work_hold_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(work_code));

  p_status_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(status)));

  p_lock_on_match_r7: assert property (@(posedge clk) disable iff (rst)
    (fuse_blow && fuse_idx == IDX_LOCK) |-> (data_fuse_q == work_code));

  p_start_on_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_byte[CMD_W-1]));
endmodule

bind otp_trim_ctrl otp_trim_chk #(.CODE_W(CODE_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .data_fuse_q(data_fuse_q), .work_code(work_code), .fuse_blow(fuse_blow),
  .fuse_idx(fuse_idx), .busy(busy), .status(status)
);

// File: tb/sim_otp_trim_ctrl.sv
module sim_otp_trim_ctrl;
  localparam int CW = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_code = '0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [CW-1:0] f_data = '0;
  logic f_test = 1'b0, f_lock = 1'b0;
  logic fuse_blow, busy;
  logic [IW-1:0] fuse_idx;
  logic [1:0] status;
  logic [CW-1:0] active_code;

  // fuse model knobs and monitor
  logic wipe = 1'b0, clr_mon = 1'b0, pre_test = 1'b0;
  logic test_ok = 1'b1, lock_ok = 1'b1;
  logic [CW-1:0] stuck = '0;
  int strobes = 0;
  logic [CW-1:0] data_mask = '0;
  logic order_ok = 1'b1;
  int last_data = -1;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  otp_trim_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .data_fuse_q(f_data),
    .test_fuse_q(f_test), .lock_fuse_q(f_lock), .fuse_blow(fuse_blow),
    .fuse_idx(fuse_idx), .busy(busy), .status(status),
    .active_code(active_code)
  );

  always @(posedge clk) begin
    if (wipe) begin
      f_data <= '0; f_test <= pre_test; f_lock <= 1'b0;
    end else if (fuse_blow) begin
      if (fuse_idx == 3'd6) begin if (test_ok) f_test <= 1'b1; end
      else if (fuse_idx == 3'd7) begin if (lock_ok) f_lock <= 1'b1; end
      else if (!stuck[fuse_idx]) f_data[fuse_idx] <= 1'b1;
    end
    if (wipe || clr_mon) begin
      strobes <= 0; data_mask <= '0; order_ok <= 1'b1; last_data <= -1;
    end else if (fuse_blow) begin
      strobes <= strobes + 1;
      if (fuse_idx < 3'd6) begin
        data_mask[fuse_idx] <= 1'b1;
        if (int'(fuse_idx) <= last_data) order_ok <= 1'b0;
        last_data <= int'(fuse_idx);
      end
    end
  end

  typedef struct packed {
    logic [5:0] code;
    logic       t_ok;
    logic       pre;
    logic [5:0] stk;
    logic       l_ok;
    logic [1:0] e_st;
    logic [3:0] e_cyc;
    logic [3:0] e_strb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{6'h2A, 1'b1, 1'b0, 6'h00, 1'b1, 2'b11, 4'd11, 4'd5},
    '{6'h15, 1'b0, 1'b0, 6'h00, 1'b1, 2'b01, 4'd2,  4'd1},
    '{6'h3F, 1'b1, 1'b0, 6'h04, 1'b1, 2'b10, 4'd9,  4'd7},
    '{6'h00, 1'b1, 1'b0, 6'h00, 1'b1, 2'b11, 4'd11, 4'd2},
    '{6'h31, 1'b1, 1'b1, 6'h00, 1'b1, 2'b11, 4'd9,  4'd4},
    '{6'h3F, 1'b1, 1'b0, 6'h00, 1'b0, 2'b10, 4'd11, 4'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic power_up();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic fresh_part(input logic pre);
    @(negedge clk) begin wipe = 1'b1; pre_test = pre; end
    @(negedge clk) wipe = 1'b0;
  endtask

  task automatic write_code(input logic [CW-1:0] c);
    @(negedge clk) begin wr_en = 1'b1; wr_code = c; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] b, output int cyc);
    @(negedge clk) clr_mon = 1'b1;
    @(negedge clk) begin clr_mon = 1'b0; cmd_valid = 1'b1; cmd_byte = b; end
    @(negedge clk) cmd_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cyc;
    // R1 reset state
    fresh_part(1'b0);
    power_up();
    chk("R1 busy", busy, 0);
    chk("R1 status", status, 2'b00);
    chk("R1 active", active_code, 32);
    chk("R1 strobe", fuse_blow, 0);
    // R2 write
    write_code(6'h2A);
    @(negedge clk);
    chk("R2 active after write", active_code, 6'h2A);
    // R3 top bit clear: no run
    run_cmd(8'h7F, cyc);
    repeat (3) @(negedge clk);
    chk("R3 no busy", cyc, 0);
    chk("R3 no strobe", strobes, 0);
    chk("R3 status", status, 2'b00);

    // table of program runs on fresh parts
    foreach (VECS[i]) begin
      fresh_part(VECS[i].pre);
      test_ok = VECS[i].t_ok; lock_ok = VECS[i].l_ok; stuck = VECS[i].stk;
      power_up();
      write_code(VECS[i].code);
      run_cmd(8'hC5, cyc);
      chk("R4 R6 R7 R8 status", status, VECS[i].e_st);
      chk("R12 busy cycles", cyc, VECS[i].e_cyc);
      chk("R5 strobe count", strobes, VECS[i].e_strb);
      chk("R5 data strobe mask", data_mask,
          (VECS[i].e_cyc == 4'd2) ? 6'h00 : VECS[i].code);
      chk("R5 ascending order", order_ok, 1);
      if (VECS[i].e_st == 2'b11) begin
        @(negedge clk);
        chk("R7 active from fuses", active_code, VECS[i].code);
      end
    end
    test_ok = 1'b1; lock_ok = 1'b1; stuck = '0;

    // R10 write ignored while busy
    fresh_part(1'b0);
    power_up();
    write_code(6'h0F);
    @(negedge clk) clr_mon = 1'b1;
    @(negedge clk) begin clr_mon = 1'b0; cmd_valid = 1'b1; cmd_byte = 8'h80; end
    @(negedge clk) begin cmd_valid = 1'b0; wr_en = 1'b1; wr_code = 6'h30; end
    @(negedge clk) wr_en = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 status after run", status, 2'b11);
    chk("R10 code kept", active_code, 6'h0F);

    // R9 locked: commands and writes have no effect
    run_cmd(8'h80, cyc);
    repeat (3) @(negedge clk);
    chk("R9 no busy", cyc, 0);
    chk("R9 no strobe", strobes, 0);
    write_code(6'h01);
    @(negedge clk);
    chk("R9 active fixed", active_code, 6'h0F);
    chk("R9 status", status, 2'b11);

    // R11 power cycle after lock
    power_up();
    chk("R11 status", status, 2'b11);
    chk("R11 active", active_code, 6'h0F);
    chk("R11 busy", busy, 0);

    // R8 retry after fatal error
    fresh_part(1'b0);
    stuck = 6'h02;
    power_up();
    write_code(6'h03);
    run_cmd(8'h80, cyc);
    chk("R8 first try fatal", status, 2'b10);
    stuck = '0;
    run_cmd(8'h80, cyc);
    chk("R8 retry status", status, 2'b11);
    chk("R8 retry skips test", cyc, 9);
    @(negedge clk);
    chk("R8 retry active", active_code, 6'h03);

    finish_run();
  end
endmodule